// File: doc/BRIEF.md
# Gated Fractional PWM Tick Divider

This block turns a stream of qualifying events into count-enable ticks for a PWM counter. The divisor is a fixed-point number with 8 integer bits and 4 fraction bits. The block carries the remainder of every division forward, so over a long run the tick rate is exactly the event rate divided by the divisor, even when the divisor has a fractional part.

A 2-bit mode input chooses the event source:
- every clock cycle (free-running), or
- cycles on which an external B pin is high, or
- rising edges of that pin, or
- falling edges of that pin.

Because of the gated modes, the same divider can act as a prescaler when the counter is used to measure pulse widths or frequencies. The B pin passes through a two-flop synchronizer inside the block before it is used. An enable input freezes the divider without losing its phase.

The output is a one-cycle pulse. It is registered, so it appears one clock after the cycle in which the qualifying event is seen.

Top module: `pwm_tick_divider`

## Requirements
- R1: Synchronous active-low reset forces the tick output low and clears the fractional remainder to zero. The first tick after reset therefore comes on the qualifying event at which the running sum first reaches the divisor.
- R2: The divisor value in sixteenths is D = div_int*16 + div_frac. Each qualifying event adds 16 to a remainder. When the sum reaches D or more, a tick is produced one cycle later and D is subtracted. For example, D = 36 (2.25) gives exactly 32 ticks in 72 events.
- R3: A divisor with div_int = 0 (below 1.0) is treated as 1.0, so every qualifying event ticks.
- R4: Mode 2'b00 (free-running) counts every enabled cycle as an event. With divisor 1.0, tick is high in every cycle that follows an enabled cycle.
- R5: Mode 2'b01 (level-gated) counts only enabled cycles on which the synchronized B pin is high. The pin reaches the gate two cycles after it is sampled, so a tick lags the pin by three cycles.
- R6: Mode 2'b10 counts one event per rising edge of the synchronized B pin. Two ticks never occur on consecutive cycles in this mode.
- R7: Mode 2'b11 counts one event per falling edge of the synchronized B pin. A rising edge alone produces no tick in this mode.
- R8: While en is low, no ticks are produced and the remainder holds its value. After enable returns, counting resumes from the held phase.
- R9: With a fractional divisor of 1.5 (div_int=1, div_frac=8) in free-running mode, starting from a zero remainder, the tick pattern is no, yes, yes, repeating. This gives 20 ticks in 30 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Divider enable; low freezes the remainder |
| mode | input | 2 | Event source: 00 free, 01 pin level, 10 pin rise, 11 pin fall |
| div_int | input | 8 | Integer part of the divisor |
| div_frac | input | 4 | Fractional part of the divisor, in sixteenths |
| pin_b | input | 1 | Asynchronous B pin; synchronized inside the block |
| tick | output | 1 | One-cycle count-enable pulse |

## Verification
A wrong remainder never shows directly at the ports. It appears as a tick that comes one or more events early or late. The bench therefore checks tick on every cycle against a model that keeps its own integer remainder, so a remainder error is caught on the first tick it displaces. Examples are a remainder cleared by a disable, or a remainder that is not reduced by the divisor. An error in the synchronizer depth or the edge detector shifts the tick by whole cycles relative to pin changes, and is caught within three cycles of the pin edge. Window tick counts over exact multiples of the divisor period also confirm that the average rate carries no drift.

// File: rtl/pwm_div_pkg.sv
// Package: shared types for the gated fractional tick divider.
// Assumes: mode codes are fixed, because software programs them directly.
package pwm_div_pkg;

    // Event source selection; the code values are architectural.
    typedef enum logic [1:0] {
        EVT_FREE  = 2'b00,
        EVT_LEVEL = 2'b01,
        EVT_RISE  = 2'b10,
        EVT_FALL  = 2'b11
    } evt_mode_e;

endpackage

// File: rtl/pwm_pin_sync.sv
// Module: pwm_pin_sync
// Brings an asynchronous pin into the clock domain through a chain of
// STAGES flops. It then reports the synchronized level and one-cycle
// rise and fall strobes.
// Assumes: STAGES >= 2; the edge strobes compare the last stage to a
// history flop.
module pwm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic lvl,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    // Shift the pin through the synchronizer and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            hist_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_async};
            hist_q  <= chain_q[STAGES-1];
        end
    end

    // Derive the level and the edge strobes from the synchronized bit.
    always_comb begin
        lvl  = chain_q[STAGES-1];
        rise = chain_q[STAGES-1] & ~hist_q;
        fall = ~chain_q[STAGES-1] & hist_q;
    end

endmodule

// File: rtl/pwm_event_sel.sv
// Module: pwm_event_sel
// Picks the qualifying-event strobe for the divider according to the
// mode code. Nothing qualifies while the enable is low.
// Assumes: the level and edge inputs are already synchronous.
module pwm_event_sel
    import pwm_div_pkg::*;
(
    input  logic       en,
    input  logic [1:0] mode,
    input  logic       lvl,
    input  logic       rise,
    input  logic       fall,
    output logic       evt
);

    // Mode multiplexer gated by the enable.
    always_comb begin
        evt = 1'b0;
        if (en) begin
            case (evt_mode_e'(mode))
                EVT_FREE:  evt = 1'b1;
                EVT_LEVEL: evt = lvl;
                EVT_RISE:  evt = rise;
                EVT_FALL:  evt = fall;
                default:   evt = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_frac_accum.sv
// Module: pwm_frac_accum
// Fixed-point remainder accumulator. Each event adds one unit (1.0,
// written 2**FRAC_W). A registered tick is emitted when the sum reaches
// the divisor, and the divisor is then subtracted.
// Assumes: divisors below 1.0 are clamped to 1.0, so the stored
// remainder always stays below the largest divisor value.
module pwm_frac_accum #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick,
    output logic [INT_W+FRAC_W-1:0] acc
);

    localparam int DIV_W = INT_W + FRAC_W;
    localparam int ONE   = 1 << FRAC_W;

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W:0]   sum;
    logic [DIV_W:0]   diff;
    logic             hit;
    logic [DIV_W-1:0] acc_q;
    logic             tick_q;

    // Clamp the divisor and form the trial sum and difference.
    always_comb begin
        div_eff = (div_int == '0) ? DIV_W'(ONE) : {div_int, div_frac};
        sum     = {1'b0, acc_q} + (DIV_W+1)'(ONE);
        hit     = (sum >= {1'b0, div_eff});
        diff    = sum - {1'b0, div_eff};
    end

    // Update the remainder on events and register the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= evt & hit;
            if (evt) begin
                acc_q <= hit ? diff[DIV_W-1:0] : sum[DIV_W-1:0];
            end
        end
    end

    assign tick = tick_q;
    assign acc  = acc_q;

endmodule

// File: rtl/pwm_tick_divider.sv
// Module: pwm_tick_divider (top)
// Gated 8.4 fractional divider that produces count-enable ticks for a
// PWM counter. It contains the pin synchronizer, the event selector and
// the remainder accumulator.
// Assumes: the divisor and mode are held quasi-static by the register
// file; the pin is asynchronous.
module pwm_tick_divider #(
    parameter int INT_W       = 8,
    parameter int FRAC_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              pin_b,
    output logic              tick
);

    localparam int DIV_W = INT_W + FRAC_W;

    logic             b_lvl;
    logic             b_rise;
    logic             b_fall;
    logic             evt;
    logic [DIV_W-1:0] acc_q;

    pwm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_b),
        .lvl       (b_lvl),
        .rise      (b_rise),
        .fall      (b_fall)
    );

    pwm_event_sel u_sel (
        .en   (en),
        .mode (mode),
        .lvl  (b_lvl),
        .rise (b_rise),
        .fall (b_fall),
        .evt  (evt)
    );

    pwm_frac_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .div_int  (div_int),
        .div_frac (div_frac),
        .tick     (tick),
        .acc      (acc_q)
    );

endmodule

// File: rtl/pwm_tick_divider_chk.sv
// Module: pwm_tick_divider_chk
// Property checker for the tick divider, attached by bind. It watches
// the ports together with the event strobe, the remainder and the
// synchronized pin level.
module pwm_tick_divider_chk #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic [1:0]              mode,
    input logic [INT_W-1:0]        div_int,
    input logic [FRAC_W-1:0]       div_frac,
    input logic                    tick,
    input logic                    evt,
    input logic [INT_W+FRAC_W-1:0] acc,
    input logic                    lvl
);

    // R1: the first cycle after reset is idle with a cleared remainder.
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!tick && acc == '0));

    // R2: a tick is always caused by an event in the previous cycle.
    a_r2_tick_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(evt));

    // R4: free-running mode at divisor 1.0 ticks every cycle.
    a_r4_unity_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'b00 && div_int == INT_W'(1) && div_frac == '0) |=> tick);

    // R5: level mode with the synchronized pin low produces no tick.
    a_r5_level_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !lvl) |=> !tick);

    // R6: rising-edge mode never ticks on two consecutive cycles.
    a_r6_rise_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b10 && $past(mode, 2) == 2'b10 && tick) |-> !$past(tick));

    // R8: disabled cycles give no tick and keep the remainder.
    a_r8_no_tick_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);
    a_r8_hold_remainder: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc));

endmodule

bind pwm_tick_divider pwm_tick_divider_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .mode     (mode),
    .div_int  (div_int),
    .div_frac (div_frac),
    .tick     (tick),
    .evt      (evt),
    .acc      (acc_q),
    .lvl      (b_lvl)
);

// File: tb/pwm_tick_divider_test.sv
// Bench: a behavioural integer model of the divider is compared with the
// tick output on every clock. Windowed tick counts check the requirements.
module pwm_tick_divider_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] div_int = 8'd1;
    logic [3:0] div_frac = 4'd0;
    logic       pin_b = 1'b0;
    logic       tick;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int win = 0;
    bit started = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    // model state
    int  m_rem = 0;
    bit  m_tick = 1'b0;
    bit  m_p1 = 1'b0, m_p2 = 1'b0, m_p3 = 1'b0;

    pwm_tick_divider uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
        .div_int(div_int), .div_frac(div_frac), .pin_b(pin_b), .tick(tick)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model: pin history of the last three samples, integer remainder.
    always @(posedge clk) begin
        int d;
        bit ev;
        cycles++;
        started = 1'b1;
        if (!rst_n) begin
            m_rem = 0; m_tick = 0; m_p1 = 0; m_p2 = 0; m_p3 = 0;
        end else begin
            d = (div_int == 0) ? 16 : div_int * 16 + div_frac;
            case (mode)
                2'b00: ev = 1;
                2'b01: ev = m_p2;
                2'b10: ev = m_p2 && !m_p3;
                default: ev = !m_p2 && m_p3;
            endcase
            ev = ev && en;
            m_tick = 0;
            if (ev) begin
                m_rem += 16;
                if (m_rem >= d) begin
                    m_rem -= d;
                    m_tick = 1;
                end
            end
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin_b;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (started && !done) chk(tick === m_tick, cur_req, int'(tick), int'(m_tick));
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            if (tick) win++;
        end
    endtask

    task automatic pin_hold(input bit lv, input int n);
        pin_b = lv;
        run(n);
    endtask

    initial begin
        run(3);
        rst_n = 1'b1;
        cur_req = "R1";
        win = 0; run(2);
        chk(win == 0, "R1 idle after reset", win, 0);

        cur_req = "R4"; en = 1'b1;
        win = 0; run(10);
        chk(win == 10, "R4 free unity", win, 10);

        cur_req = "R9"; div_frac = 4'd8;
        win = 0; run(30);
        chk(win == 20, "R9 divisor 1.5", win, 20);

        cur_req = "R2"; div_int = 8'd2; div_frac = 4'd4;
        win = 0; run(72);
        chk(win == 32, "R2 divisor 2.25", win, 32);

        cur_req = "R3"; div_int = 8'd0; div_frac = 4'd5;
        win = 0; run(8);
        chk(win == 8, "R3 clamp below 1.0", win, 8);

        cur_req = "R8"; div_int = 8'd3; div_frac = 4'd0;
        run(4);
        en = 1'b0;
        win = 0; run(20);
        chk(win == 0, "R8 no tick disabled", win, 0);
        en = 1'b1;
        win = 0; run(2);
        chk(win == 1, "R8 phase held", win, 1);

        cur_req = "R5"; mode = 2'b01; div_int = 8'd1;
        win = 0; pin_hold(1'b1, 6); pin_hold(1'b0, 10);
        chk(win == 6, "R5 level unity", win, 6);
        div_int = 8'd2;
        win = 0; pin_hold(1'b1, 10); pin_hold(1'b0, 6);
        chk(win == 5, "R5 level div 2", win, 5);

        cur_req = "R6"; mode = 2'b10; div_int = 8'd1;
        win = 0;
        for (int i = 0; i < 5; i++) begin pin_hold(1'b1, 2); pin_hold(1'b0, 2); end
        run(4);
        chk(win == 5, "R6 rising unity", win, 5);
        div_int = 8'd2;
        win = 0;
        for (int i = 0; i < 6; i++) begin pin_hold(1'b1, 3); pin_hold(1'b0, 3); end
        run(4);
        chk(win == 3, "R6 rising div 2", win, 3);

        cur_req = "R7"; mode = 2'b11; div_int = 8'd1;
        win = 0;
        for (int i = 0; i < 5; i++) begin pin_hold(1'b1, 2); pin_hold(1'b0, 2); end
        run(4);
        chk(win == 5, "R7 falling unity", win, 5);
        win = 0; pin_hold(1'b1, 8);
        chk(win == 0, "R7 rise alone quiet", win, 0);
        win = 0; pin_hold(1'b0, 6);
        chk(win == 1, "R7 fall after rise", win, 1);

        cur_req = "R1"; mode = 2'b00; div_int = 8'd3;
        run(2);
        rst_n = 1'b0; run(2);
        rst_n = 1'b1;
        win = 0; run(1);
        chk(win == 0, "R1 reset clears tick", win, 0);
        win = 0; run(3);
        chk(win == 1, "R1 remainder cleared", win, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule